// File: doc/BRIEF.md
# Quadword Move Decode and Execute Unit

This unit receives an instruction that has already been fetched and split into byte fields: the mandatory prefix, the vector-prefix fields, the REX.R bit, the opcode byte that follows 0F, and the ModRM byte. It also receives the read data of one source register. It decodes the quadword-move family and works out the direction of the move, which operand is the register and which is the register-or-memory operand, and whether the destination is a 64-bit or a 128-bit register. It then produces one of four results: a register writeback, a 64-bit store, a 64-bit load followed by a writeback, or an invalid-opcode flag.

A 128-bit destination always gets its upper quadword cleared. A 64-bit destination is written with all 64 source bits. Encodings that misuse a reserved vector-prefix field or the mandatory prefix raise the invalid-opcode flag, and no write or memory request follows.

Control is a two-state machine. ST_IDLE accepts an instruction. It takes the transition IDLE_TO_LOAD when a legal instruction has a memory source, and otherwise stays in ST_IDLE (IDLE_HOLD). ST_LOAD waits one cycle for load data, writes it back, and takes the transition LOAD_TO_IDLE unconditionally.

Top module: `qmv_exec`

## Requirements
- R1: After reset, wb_en, st_valid, ld_req and ill are all 0.
- R2: Opcode 6F with mand_pfx=0 (none) and no vector prefix writes 64-bit register reg=modrm[5:3] (wb_cls=0). The source is 64-bit register rm=modrm[2:0] when modrm[7:6]=11, and otherwise a load is issued. All 64 bits are copied.
- R3: Opcode 7F with mand_pfx=0 and no vector prefix reads 64-bit register reg. When modrm[7:6]=11 it writes 64-bit register rm; otherwise it issues a store of all 64 bits.
- R4: Opcode 7E with mand_pfx=2 (F3) writes 128-bit register reg (wb_cls=1). wb_data[63:0] is the source quadword and wb_data[127:64] is 0. The source is the low quadword of 128-bit register rm, or a load when mod is not 11.
- R5: Opcode D6 with mand_pfx=1 (66) takes the low quadword of 128-bit register reg. It writes that quadword to 128-bit register rm with the upper half zeroed, or stores it when mod is not 11.
- R6: With vec_pfx=1, a vec_vvvv value other than 4'b1111 sets ill.
- R7: With vec_pfx=1, vec_len=1 sets ill.
- R8: Opcodes 7E and D6 without their own mandatory prefix, 6F and 7F with any prefix or with vec_pfx=1, and every other opcode set ill. In each of these cases wb_en, st_valid and ld_req stay 0.
- R9: With long_mode=1, rex_r=1 and vec_pfx=0, the reg index of a 128-bit operand becomes {1,modrm[5:3]}. Under vec_pfx=1, or for a 64-bit operand, rex_r is ignored.
- R10: A memory-source instruction raises ld_req for one cycle. The memory returns ld_data while ld_req is 1, and the writeback follows in the next cycle. An ins_valid that arrives while ld_req is 1 is ignored.
- R11: Every result (wb_en, st_valid, ld_req or ill) is a one-cycle pulse in the cycle after ins_valid, and at most one of the four is set in any cycle.
- R12: rd_idx and rd_cls name the source register combinationally in the cycle in which ins_valid is presented. Encoding: 0 = 64-bit file, 1 = 128-bit file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction fields are valid this cycle |
| long_mode | input | 1 | 64-bit mode |
| rex_r | input | 1 | REX.R bit from a REX prefix |
| vec_pfx | input | 1 | Instruction uses a vector-prefix encoding |
| vec_vvvv | input | 4 | Extra-source field of the vector prefix |
| vec_len | input | 1 | Vector-length bit (1 = 256-bit) |
| mand_pfx | input | 2 | Mandatory prefix: 0 none, 1 66, 2 F3, 3 F2 |
| opcode | input | 8 | Opcode byte after 0F |
| modrm | input | 8 | ModRM byte |
| rd_idx | output | 4 | Source register index |
| rd_cls | output | 1 | Source register file (0 64-bit, 1 128-bit) |
| rd_data | input | 128 | Source register read data |
| ld_data | input | 64 | Load data, valid while ld_req is 1 |
| wb_en | output | 1 | Register writeback strobe |
| wb_cls | output | 1 | Writeback register file |
| wb_idx | output | 4 | Writeback register index |
| wb_data | output | 128 | Writeback data |
| st_valid | output | 1 | Store request |
| st_data | output | 64 | Store data |
| ld_req | output | 1 | Load request |
| ill | output | 1 | Invalid-opcode flag |

## Verification
If the controller stays in ST_LOAD too long or leaves it too early, the writeback pulse either goes missing or repeats one cycle after ld_req, or a second instruction gets through during the wait. All of these show up within two cycles of the load. A wrong decode latch shows up on the very next cycle as the wrong strobe, class or index, or as nonzero upper bits on a 128-bit write. Random encodings, including illegal prefix and field combinations, are compared against a model in the bench on every instruction.

// File: rtl/qmv_pkg.sv
package qmv_pkg;
    localparam int IW = 4;

    typedef enum logic [1:0] {
        PFX_NONE = 2'd0,
        PFX_66   = 2'd1,
        PFX_F3   = 2'd2,
        PFX_F2   = 2'd3
    } mpfx_e;

    typedef enum logic {
        CLS_Q = 1'b0,
        CLS_X = 1'b1
    } rcls_e;

    typedef struct packed {
        logic          ill;
        logic          mem_src;
        logic          mem_dst;
        rcls_e         dst_cls;
        logic [IW-1:0] dst_idx;
        rcls_e         src_cls;
        logic [IW-1:0] src_idx;
    } dec_t;
endpackage

// File: rtl/qmv_decode.sv
module qmv_decode
    import qmv_pkg::*;
(
    input  logic       long_mode,
    input  logic       rex_r,
    input  logic       vec_pfx,
    input  logic [3:0] vec_vvvv,
    input  logic       vec_len,
    input  logic [1:0] mand_pfx,
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    output dec_t       dec
);
    localparam int FW = 3;

    logic          reg_form;
    logic          ext_r;
    logic [IW-1:0] reg_q, reg_x, rm_i;
    logic          ok;

    always_comb begin
        reg_form = (modrm[7:6] == 2'b11);
        ext_r    = long_mode && rex_r && !vec_pfx;
        reg_q    = {{(IW-FW){1'b0}}, modrm[5:3]};
        reg_x    = {{(IW-FW-1){1'b0}}, ext_r, modrm[5:3]};
        rm_i     = {{(IW-FW){1'b0}}, modrm[2:0]};
        ok       = 1'b0;
        dec      = '0;
        unique case (opcode)
            8'h6F: begin
                ok          = (mand_pfx == PFX_NONE) && !vec_pfx;
                dec.dst_cls = CLS_Q;
                dec.dst_idx = reg_q;
                dec.src_cls = CLS_Q;
                dec.src_idx = rm_i;
                dec.mem_src = !reg_form;
            end
            8'h7F: begin
                ok          = (mand_pfx == PFX_NONE) && !vec_pfx;
                dec.src_cls = CLS_Q;
                dec.src_idx = reg_q;
                dec.dst_cls = CLS_Q;
                dec.dst_idx = rm_i;
                dec.mem_dst = !reg_form;
            end
            8'h7E: begin
                ok          = (mand_pfx == PFX_F3);
                dec.dst_cls = CLS_X;
                dec.dst_idx = reg_x;
                dec.src_cls = CLS_X;
                dec.src_idx = rm_i;
                dec.mem_src = !reg_form;
            end
            8'hD6: begin
                ok          = (mand_pfx == PFX_66);
                dec.src_cls = CLS_X;
                dec.src_idx = reg_x;
                dec.dst_cls = CLS_X;
                dec.dst_idx = rm_i;
                dec.mem_dst = !reg_form;
            end
            default: ok = 1'b0;
        endcase
        if (vec_pfx && ((vec_vvvv != 4'hF) || vec_len))
            ok = 1'b0;
        dec.ill = !ok;
    end
endmodule

// File: rtl/qmv_ctrl.sv
module qmv_ctrl
    import qmv_pkg::*;
#(
    parameter int QW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_valid,
    input  dec_t            dec,
    input  logic [2*QW-1:0] rd_data,
    input  logic [QW-1:0]   ld_data,
    output logic            wb_en,
    output rcls_e           wb_cls,
    output logic [IW-1:0]   wb_idx,
    output logic [2*QW-1:0] wb_data,
    output logic            st_valid,
    output logic [QW-1:0]   st_data,
    output logic            ld_req,
    output logic            ill
);
    localparam int VW = 2 * QW;

    typedef enum logic {ST_IDLE, ST_LOAD} st_e;
    st_e           state, state_nx;
    rcls_e         pend_cls;
    logic [IW-1:0] pend_idx;

    function automatic logic [VW-1:0] zext(input logic [QW-1:0] q);
        return {{QW{1'b0}}, q};
    endfunction

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ins_valid && !dec.ill && dec.mem_src) state_nx = ST_LOAD;
            ST_LOAD: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en    <= 1'b0;
            wb_cls   <= CLS_Q;
            wb_idx   <= '0;
            wb_data  <= '0;
            st_valid <= 1'b0;
            st_data  <= '0;
            ld_req   <= 1'b0;
            ill      <= 1'b0;
            pend_cls <= CLS_Q;
            pend_idx <= '0;
        end else begin
            wb_en    <= 1'b0;
            st_valid <= 1'b0;
            ld_req   <= 1'b0;
            ill      <= 1'b0;
            unique case (state)
                ST_IDLE: if (ins_valid) begin
                    if (dec.ill) begin
                        ill <= 1'b1;
                    end else if (dec.mem_src) begin
                        ld_req   <= 1'b1;
                        pend_cls <= dec.dst_cls;
                        pend_idx <= dec.dst_idx;
                    end else if (dec.mem_dst) begin
                        st_valid <= 1'b1;
                        st_data  <= rd_data[QW-1:0];
                    end else begin
                        wb_en   <= 1'b1;
                        wb_cls  <= dec.dst_cls;
                        wb_idx  <= dec.dst_idx;
                        wb_data <= zext(rd_data[QW-1:0]);
                    end
                end
                ST_LOAD: begin
                    wb_en   <= 1'b1;
                    wb_cls  <= pend_cls;
                    wb_idx  <= pend_idx;
                    wb_data <= zext(ld_data);
                end
            endcase
        end
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, st_valid, ld_req, ill}));                              // R11
    AST_XMM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_cls == CLS_X) |-> (wb_data[VW-1:QW] == '0));               // R4
    AST_LOAD_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> (wb_en && !ld_req && !ill && !st_valid));                    // R10
    AST_RESULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en || st_valid || ld_req || ill) |-> ($past(ins_valid) || $past(ld_req))); // R11
    AST_ILL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ill |-> (!wb_en && !st_valid && !ld_req));                              // R8
endmodule

// File: rtl/qmv_exec.sv
module qmv_exec
    import qmv_pkg::*;
#(
    parameter int QW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_valid,
    input  logic            long_mode,
    input  logic            rex_r,
    input  logic            vec_pfx,
    input  logic [3:0]      vec_vvvv,
    input  logic            vec_len,
    input  logic [1:0]      mand_pfx,
    input  logic [7:0]      opcode,
    input  logic [7:0]      modrm,
    output logic [IW-1:0]   rd_idx,
    output logic            rd_cls,
    input  logic [2*QW-1:0] rd_data,
    input  logic [QW-1:0]   ld_data,
    output logic            wb_en,
    output logic            wb_cls,
    output logic [IW-1:0]   wb_idx,
    output logic [2*QW-1:0] wb_data,
    output logic            st_valid,
    output logic [QW-1:0]   st_data,
    output logic            ld_req,
    output logic            ill
);
    dec_t  dec;
    rcls_e wb_cls_e;

    qmv_decode u_dec (
        .long_mode (long_mode),
        .rex_r     (rex_r),
        .vec_pfx   (vec_pfx),
        .vec_vvvv  (vec_vvvv),
        .vec_len   (vec_len),
        .mand_pfx  (mand_pfx),
        .opcode    (opcode),
        .modrm     (modrm),
        .dec       (dec)
    );

    qmv_ctrl #(.QW(QW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_valid (ins_valid),
        .dec       (dec),
        .rd_data   (rd_data),
        .ld_data   (ld_data),
        .wb_en     (wb_en),
        .wb_cls    (wb_cls_e),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data),
        .st_valid  (st_valid),
        .st_data   (st_data),
        .ld_req    (ld_req),
        .ill       (ill)
    );

    assign wb_cls = wb_cls_e;
    assign rd_idx = dec.src_idx;
    assign rd_cls = dec.src_cls;
endmodule

// File: tb/qmv_exec_test.sv
module qmv_exec_test;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ins_valid = 1'b0, long_mode = 1'b0, rex_r = 1'b0, vec_pfx = 1'b0, vec_len = 1'b0;
    logic [3:0]   vec_vvvv = 4'hF;
    logic [1:0]   mand_pfx = 2'd0;
    logic [7:0]   opcode = 8'h00, modrm = 8'h00;
    logic [3:0]   rd_idx, wb_idx;
    logic         rd_cls, wb_cls, wb_en, st_valid, ld_req, ill;
    logic [127:0] rd_data = '0, wb_data;
    logic [63:0]  ld_data = '0, st_data;
    int nchk = 0, nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    qmv_exec uut (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // model: ok, memory source, memory destination, dest class/index, source class/index
    task automatic model(input logic [7:0] op, input logic [1:0] mp, input bit vx, input logic [3:0] vv,
                         input bit vl, input bit lm, input bit rr, input logic [7:0] mr,
                         output bit ok, output bit msrc, output bit mdst, output bit dcls,
                         output logic [3:0] didx, output bit scls, output logic [3:0] sidx);
        logic [3:0] rq, rx, rm;
        bit regf;
        regf = (mr[7:6] == 2'b11);
        rq = {1'b0, mr[5:3]};
        rx = {lm && rr && !vx, mr[5:3]};
        rm = {1'b0, mr[2:0]};
        ok = 0; msrc = 0; mdst = 0; dcls = 0; didx = 0; scls = 0; sidx = 0;
        case (op)
            8'h6F: begin ok = (mp == 0) && !vx; dcls = 0; didx = rq; scls = 0; sidx = rm; msrc = !regf; end
            8'h7F: begin ok = (mp == 0) && !vx; scls = 0; sidx = rq; dcls = 0; didx = rm; mdst = !regf; end
            8'h7E: begin ok = (mp == 2); dcls = 1; didx = rx; scls = 1; sidx = rm; msrc = !regf; end
            8'hD6: begin ok = (mp == 1); scls = 1; sidx = rx; dcls = 1; didx = rm; mdst = !regf; end
            default: ok = 0;
        endcase
        if (vx && (vv != 4'hF || vl)) ok = 0;
    endtask

    task automatic run(input string req, input logic [7:0] op, input logic [1:0] mp, input bit vx,
                       input logic [3:0] vv, input bit vl, input bit lm, input bit rr,
                       input logic [7:0] mr, input bit poke);
        bit ok, msrc, mdst, dcls, scls;
        logic [3:0] didx, sidx;
        logic [127:0] rdv;
        logic [63:0] ldv;
        model(op, mp, vx, vv, vl, lm, rr, mr, ok, msrc, mdst, dcls, didx, scls, sidx);
        rdv = {$urandom, $urandom, $urandom, $urandom};
        ldv = {$urandom, $urandom};
        @(negedge clk);
        opcode = op; mand_pfx = mp; vec_pfx = vx; vec_vvvv = vv; vec_len = vl;
        long_mode = lm; rex_r = rr; modrm = mr; rd_data = rdv; ld_data = ldv; ins_valid = 1'b1;
        #1;
        if (ok && !msrc) begin
            chk({req, " R12 rd_idx"}, 128'(rd_idx), 128'(sidx));
            chk({req, " R12 rd_cls"}, 128'(rd_cls), 128'(scls));
        end
        @(negedge clk);
        ins_valid = 1'b0;
        chk({req, " R8 ill"}, 128'(ill), 128'(!ok));
        chk({req, " R11 ld_req"}, 128'(ld_req), 128'(ok && msrc));
        chk({req, " R11 st_valid"}, 128'(st_valid), 128'(ok && mdst));
        chk({req, " R11 wb_en"}, 128'(wb_en), 128'(ok && !msrc && !mdst));
        if (ok && mdst) chk({req, " st_data"}, 128'(st_data), 128'(rdv[63:0]));
        if (ok && !msrc && !mdst) begin
            chk({req, " wb_cls"}, 128'(wb_cls), 128'(dcls));
            chk({req, " R9 wb_idx"}, 128'(wb_idx), 128'(didx));
            chk({req, " wb_data"}, wb_data, {64'h0, rdv[63:0]});
        end
        if (ok && msrc) begin
            if (poke) begin
                opcode = 8'h00; ins_valid = 1'b1;
            end
            @(negedge clk);
            ins_valid = 1'b0;
            chk({req, " R10 load wb_en"}, 128'(wb_en), 128'(1));
            chk({req, " R10 ill"}, 128'(ill), 128'(0));
            chk({req, " R10 wb_cls"}, 128'(wb_cls), 128'(dcls));
            chk({req, " R10 wb_idx"}, 128'(wb_idx), 128'(didx));
            chk({req, " R10 wb_data"}, wb_data, {64'h0, ldv});
            if (poke) begin
                @(negedge clk);
                chk({req, " R10 ignored"}, 128'({wb_en, st_valid, ld_req, ill}), 128'(0));
            end
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk("R1 reset", 128'({wb_en, st_valid, ld_req, ill}), 128'(0));
        rst_n = 1'b1;
        // directed
        run("R2 6F reg",  8'h6F, 0, 0, 4'hF, 0, 1, 0, 8'hD5, 0);
        run("R2 6F mem",  8'h6F, 0, 0, 4'hF, 0, 1, 0, 8'h4B, 0);
        run("R3 7F reg",  8'h7F, 0, 0, 4'hF, 0, 1, 1, 8'hFA, 0);
        run("R3 7F mem",  8'h7F, 0, 0, 4'hF, 0, 0, 0, 8'h08, 0);
        run("R4 7E reg",  8'h7E, 2, 0, 4'hF, 0, 0, 0, 8'hC7, 0);
        run("R4 7E vmem", 8'h7E, 2, 1, 4'hF, 0, 1, 0, 8'h96, 0);
        run("R5 D6 reg",  8'hD6, 1, 0, 4'hF, 0, 1, 0, 8'hE1, 0);
        run("R5 D6 mem",  8'hD6, 1, 1, 4'hF, 0, 1, 0, 8'h30, 0);
        run("R6 vvvv",    8'h7E, 2, 1, 4'h7, 0, 1, 0, 8'hC1, 0);
        run("R7 vlen",    8'hD6, 1, 1, 4'hF, 1, 1, 0, 8'hC1, 0);
        run("R8 7E nopf", 8'h7E, 0, 0, 4'hF, 0, 1, 0, 8'hC1, 0);
        run("R8 D6 F3",   8'hD6, 2, 0, 4'hF, 0, 1, 0, 8'hC1, 0);
        run("R8 6F vex",  8'h6F, 0, 1, 4'hF, 0, 1, 0, 8'hC1, 0);
        run("R8 other",   8'h10, 0, 0, 4'hF, 0, 1, 0, 8'hC1, 0);
        run("R9 rexr",    8'h7E, 2, 0, 4'hF, 0, 1, 1, 8'hEA, 0);
        run("R9 rex vex", 8'h7E, 2, 1, 4'hF, 0, 1, 1, 8'hEA, 0);
        run("R9 rex 32",  8'hD6, 1, 0, 4'hF, 0, 0, 1, 8'hDC, 0);
        run("R9 rex mm",  8'h6F, 0, 0, 4'hF, 0, 1, 1, 8'hFB, 0);
        run("R10 poke",   8'h7E, 2, 0, 4'hF, 0, 1, 1, 8'h5D, 1);
        // random
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            int s;
            s = $urandom % 5;
            op = (s == 0) ? 8'h6F : (s == 1) ? 8'h7F : (s == 2) ? 8'h7E : (s == 3) ? 8'hD6 : 8'($urandom);
            run("R2-R5 rnd", op, 2'($urandom), ($urandom % 4) == 0,
                (($urandom % 6) == 0) ? 4'($urandom) : 4'hF, ($urandom % 8) == 0,
                1'($urandom), 1'($urandom), 8'($urandom), ($urandom % 4) == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule